// File: doc/BRIEF.md
# Broadcast-Capable Slave Select Decoder

This block is the bus-side front end of one plug-in slave on a memory-mapped control bus. The host drives an address, an active-low data strobe and a read/not-write line. When the strobe falls, the decoder latches the address fields and the transfer direction. While the strobe stays low it drives an active-low read or write strobe, one of five active-low chip selects, or one of two active-low register selects. Each slave copy is built with its own `SLOT` parameter. The slave responds only when the address lies in the control window and the address bit for its slot is set. Because slot bits are one-hot per slave, one host access can reach any group of slaves at once.

Inside a slave, a four-bit chip code picks the target. The code can select one chip, all chips together (broadcast), or one of two register selects. Every other code selects nothing. When a selected write finishes, the strobe returns high and a one-cycle capture pulse tells the register logic to take the write data. The strobe is sampled on the block clock. Each result appears on the clock edge that first sees the strobe change.

Top module: `hotbit_slave_decoder`

## Requirements
- R1: During and right after reset, every active-low output (`rd_n`, `wr_n`, `cs_n`, `rsel_n`) is high and `wcap` is low.
- R2: A strobe whose address bits 19..16 are not 4'hD selects nothing: no read, write, chip or register select, and no capture pulse.
- R3: With bits 19..16 equal to 4'hD, the slave responds exactly when address bit (8+SLOT) is set, whatever the other bits in 11..8 hold.
- R4: For a responding slave, chip code (address bits 7..4) 8+i, i in 0..4, drives `cs_n[i]` low and leaves the other chip selects high.
- R5: Chip code 4'hF drives all five `cs_n` bits low together. No other code drives more than one low.
- R6: Code 4'hD drives `rsel_n[0]` low and code 4'hE drives `rsel_n[1]` low. Codes 0..7 drive no chip or register select.
- R7: On a responding access, `rd_n` goes low when `rw` was 1 at the fall and `wr_n` when it was 0, never both. Outputs change on the first clock edge that samples the strobe low, and return high on the first edge that samples it high.
- R8: The address and direction taken on the falling strobe are held. Changes on `addr` or `rw` while the strobe stays low do not alter any output.
- R9: On the edge that first samples the strobe high after a responding write, `wcap` is high for exactly one cycle. After reads and non-responding accesses it stays low.
- R10: With SLOT=2, address 20'hD0481 read selects chip 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W-1 | Host address bits ADDR_W-1..1 (bit 0 implied 1) |
| rw | input | 1 | 1 = read, 0 = write |
| strb_n | input | 1 | Active-low data strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | NCHIP | Active-low chip selects |
| rsel_n | output | 2 | Active-low register selects |
| wcap | output | 1 | One-cycle write-data capture pulse |

## Verification
Every select and strobe is due one clock edge after the input strobe level changes. The bench drives inputs on falling edges and samples on the next falling edge, which lies after exactly one rising edge. The capture pulse is checked on that same half-cycle-later sample after the strobe rises, and checked low again one cycle later. The sweep covers both window nibbles, all sixteen slot-bit patterns, all sixteen chip codes and both directions. In each access the address and direction are disturbed mid-strobe and outputs are rechecked at the next sample.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam logic [3:0] WINDOW_TAG = 4'hD;
  localparam logic [3:0] CODE_CHIP0 = 4'h8;
  localparam logic [3:0] CODE_RSEL0 = 4'hD;
  localparam logic [3:0] CODE_BCAST = 4'hF;

  typedef struct packed {
    logic       hit;
    logic       rd;
    logic [3:0] code;
  } hbd_latch_t;
endpackage

// File: rtl/hbd_capture.sv
module hbd_capture #(
  parameter int ADDR_W = 20,
  parameter int SLOT   = 0,
  parameter int NSLOT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr,
  input  logic              rw,
  input  logic              strb_n,
  output logic              act,
  output hbd_pkg::hbd_latch_t lat,
  output logic              wcap
);
  import hbd_pkg::*;
  localparam int TAG_LO = ADDR_W - 4;
  localparam int HOT_LO = 8;
  localparam int HOT_BIT = HOT_LO + SLOT;

  logic strb_q;
  logic fall, rise;
  logic hit_now;
  logic unused_addr;

  assign unused_addr = ^addr;
  assign fall    = strb_q & ~strb_n;
  assign rise    = ~strb_q & strb_n;
  assign hit_now = (addr[ADDR_W-1:TAG_LO] == WINDOW_TAG) && addr[HOT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      act    <= 1'b0;
      lat    <= '0;
      wcap   <= 1'b0;
    end else begin
      strb_q <= strb_n;
      wcap   <= 1'b0;
      if (fall) begin
        act      <= hit_now;
        lat.hit  <= hit_now;
        lat.rd   <= rw;
        lat.code <= addr[7:4];
      end else if (strb_n) begin
        act <= 1'b0;
        if (rise && act && !lat.rd) wcap <= 1'b1;
      end
    end
  end

  // R9: capture pulse only right after an active write phase
  assert_wcap_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wcap |-> ($past(act) && !$past(lat.rd)));
  // R7: a high strobe clears the active phase on the next edge
  assert_idle_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb_n |=> !act);
  initial begin
    assert (SLOT >= 0 && SLOT < NSLOT) else $error("SLOT out of range");
  end
endmodule

// File: rtl/hbd_select.sv
module hbd_select #(
  parameter int NCHIP = 5
) (
  input  logic                act,
  input  hbd_pkg::hbd_latch_t lat,
  output logic                rd_n,
  output logic                wr_n,
  output logic [NCHIP-1:0]    cs_n,
  output logic [1:0]          rsel_n
);
  import hbd_pkg::*;
  logic bcast;
  assign bcast = (lat.code == CODE_BCAST);
  assign rd_n  = ~(act & lat.rd);
  assign wr_n  = ~(act & ~lat.rd);

  for (genvar i = 0; i < NCHIP; i++) begin : g_cs
    localparam logic [3:0] MY_CODE = CODE_CHIP0 + 4'(i);
    assign cs_n[i] = ~(act & ((lat.code == MY_CODE) | bcast));
  end
  for (genvar j = 0; j < 2; j++) begin : g_rs
    localparam logic [3:0] MY_CODE = CODE_RSEL0 + 4'(j);
    assign rsel_n[j] = ~(act & (lat.code == MY_CODE));
  end

  // R5: chip selects are none, one, or all
  always_comb begin
    assert ($countones(~cs_n) <= 1 || $countones(~cs_n) == NCHIP)
      else $error("assert_cs_group_R5 failed");
  end
  // R7: never read and write at once
  always_comb begin
    assert (rd_n | wr_n) else $error("assert_rw_excl_R7 failed");
  end
endmodule

// File: rtl/hotbit_slave_decoder.sv
module hotbit_slave_decoder #(
  parameter int ADDR_W = 20,
  parameter int NSLOT  = 4,
  parameter int SLOT   = 0,
  parameter int NCHIP  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr,
  input  logic              rw,
  input  logic              strb_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [NCHIP-1:0]  cs_n,
  output logic [1:0]        rsel_n,
  output logic              wcap
);
  import hbd_pkg::*;
  logic       act;
  hbd_latch_t lat;

  hbd_capture #(.ADDR_W(ADDR_W), .SLOT(SLOT), .NSLOT(NSLOT)) u_cap (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .strb_n(strb_n),
    .act(act), .lat(lat), .wcap(wcap)
  );

  hbd_select #(.NCHIP(NCHIP)) u_sel (
    .act(act), .lat(lat), .rd_n(rd_n), .wr_n(wr_n),
    .cs_n(cs_n), .rsel_n(rsel_n)
  );

  // R8: selects hold while the strobe stays low
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_n && !$past(strb_n)) |=> ($stable(cs_n) && $stable(rsel_n) && $stable(rd_n)));
  // R6: register selects never overlap chip selects
  assert_rsel_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel_n != 2'b11) |-> (&cs_n));
endmodule

// File: tb/sim_hotbit_slave_decoder.sv
module sim_hotbit_slave_decoder;
  localparam int SLOT = 2;
  logic clk = 0, rst_n = 0;
  logic [19:1] addr = '0;
  logic rw = 1, strb_n = 1;
  logic rd_n, wr_n, wcap;
  logic [4:0] cs_n;
  logic [1:0] rsel_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hotbit_slave_decoder #(.SLOT(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .strb_n(strb_n),
    .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n), .rsel_n(rsel_n), .wcap(wcap));

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expect_out(logic [3:0] tag, logic [3:0] hot,
                                            logic [3:0] code, logic r);
    logic hit = (tag == 4'hD) && hot[SLOT];
    logic [4:0] cs = '1;
    logic [1:0] rs = '1;
    for (int i = 0; i < 5; i++)
      if (hit && (code == 4'(8 + i) || code == 4'hF)) cs[i] = 1'b0;
    if (hit && code == 4'hD) rs[0] = 1'b0;
    if (hit && code == 4'hE) rs[1] = 1'b0;
    return {~(hit & r), ~(hit & ~r), cs, rs, 1'b0};
  endfunction

  task automatic access(logic [3:0] tag, logic [3:0] hot, logic [3:0] code,
                        logic r, string req);
    logic [19:0] a = {tag, 4'h0, hot, code, 4'h1};
    logic [9:0] e = expect_out(tag, hot, code, r);
    logic hit = (tag == 4'hD) && hot[SLOT];
    @(negedge clk);
    addr = a[19:1]; rw = r; strb_n = 0;
    @(negedge clk);
    chk(req, {rd_n, wr_n, cs_n, rsel_n, wcap}, e);
    addr = ~a[19:1]; rw = ~r;
    @(negedge clk);
    chk("R8", {rd_n, wr_n, cs_n, rsel_n, wcap}, e);
    strb_n = 1;
    @(negedge clk);
    chk("R9", {rd_n, wr_n, cs_n, rsel_n, wcap}, {9'h1FF, hit & ~r});
    @(negedge clk);
    chk("R9", {9'h1FF, wcap}, {9'h1FF, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {rd_n, wr_n, cs_n, rsel_n, wcap}, 10'b1111111110);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {rd_n, wr_n, cs_n, rsel_n, wcap}, 10'b1111111110);
    // R10 directed example
    access(4'hD, 4'h4, 4'h8, 1'b1, "R10");
    for (int t = 0; t < 2; t++)
      for (int h = 0; h < 16; h++)
        for (int c = 0; c < 16; c++)
          for (int r = 0; r < 2; r++) begin
            string req;
            if (t == 0) req = "R2";
            else if (!h[SLOT]) req = "R3";
            else if (c >= 8 && c <= 12) req = "R4";
            else if (c == 15) req = "R5";
            else if (c < 8 || c == 13 || c == 14) req = "R6";
            else req = "R7";
            access(t == 0 ? 4'hC : 4'hD, 4'(h), 4'(c), r[0], req);
          end
    // R7 read/write strobe direction on a plain chip code
    access(4'hD, 4'hF, 4'h9, 1'b0, "R7");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule